// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoint

This block renames the registers of one instruction per cycle. A map table holds, for each architectural register, the physical register that currently carries its value. Source operands are renamed by reading that table. A destination takes the register at the head of a free-register queue, and the map entry for that destination is pointed at it. The physical register the destination used to map to is reported alongside, so that it can be handed back once the instruction retires.

A branch saves a snapshot of the whole map table and the free-queue read position. When the branch turns out to be mispredicted, both are put back in one cycle. When it resolves correctly, the snapshot is dropped. Only one snapshot exists at a time. A retiring instruction returns its previous physical register to the tail of the free queue, and that return survives a restore in the same cycle. The ready-bit scoreboard and the physical register data lie outside this block.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i from 0 to 15.
- R2: After reset, successive destination renames receive physical registers 16, 17, ... 47 in that order, and `out_prev_p` gives the mapping the destination held just before.
- R3: Sources are looked up before the same instruction's destination update takes effect, so a source equal to the destination returns the old mapping.
- R4: After a destination rename, later lookups of that architectural register return the newly allocated physical register.
- R5: When the free queue is empty, a rename with `ren_wr`=1 is stalled (`ren_stall`=1, no output), while a rename with `ren_wr`=0 still proceeds.
- R6: A register returned on `commit_valid` joins the tail of the free queue and is allocated only after every register already queued ahead of it.
- R7: An accepted rename with `ren_branch`=1 saves the map table (including that rename's own destination update) and the free-queue head. Another branch rename is stalled while the snapshot is live.
- R8: `resolve_valid` with `resolve_wrong`=1 while a snapshot is live restores the map table and the free-queue head in one cycle. The next allocation returns the register that followed the branch's own allocation.
- R9: `resolve_valid` with `resolve_wrong`=0 discards the snapshot. A later wrong resolution then has no effect, and a new branch is accepted.
- R10: A register returned on `commit_valid` in the same cycle as a restore stays in the free queue after the restore.
- R11: Results are registered: `out_valid` is high in the cycle after an accepted rename and low otherwise. A rename presented in a restore cycle is stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | A rename request is present |
| ren_wr | input | 1 | The instruction writes a destination |
| ren_branch | input | 1 | The instruction is a branch; save a snapshot |
| ren_dst | input | 4 | Destination architectural register |
| ren_src_a | input | 4 | First source architectural register |
| ren_src_b | input | 4 | Second source architectural register |
| ren_stall | output | 1 | Request cannot be accepted this cycle |
| out_valid | output | 1 | Registered rename result is valid |
| out_has_dst | output | 1 | Result carries a destination allocation |
| out_src_a_p | output | 6 | Physical register for the first source |
| out_src_b_p | output | 6 | Physical register for the second source |
| out_dst_p | output | 6 | Newly allocated physical register |
| out_prev_p | output | 6 | Previous mapping of the destination |
| resolve_valid | input | 1 | The pending branch resolves |
| resolve_wrong | input | 1 | The resolution is a mispredict |
| commit_valid | input | 1 | A retiring instruction releases a register |
| commit_free_p | input | 6 | Physical register being released |

## Verification
Two events can collide in one cycle: a mispredict restore and the release of a register by a retiring instruction. The bench drives both on the same edge, together with a rename request that must be held off. It then counts the allocations that follow. The first must be the register queued right after the branch's own allocation, and the next must be the register that was released during the restore. This shows that the release survived the head rewind. The map contents after the restore are judged by plain source lookups of registers changed before and after the branch.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_ARCH_REGS = 16;
  localparam int RN_PHYS_REGS = 48;
endpackage

// File: rtl/rn_free_list.sv
// Circular queue of free physical registers. The read pointer can be
// saved at a branch and put back on a mispredict; the write pointer
// always keeps moving, so releases are never lost.
module rn_free_list #(
  parameter int DEPTH = 32,
  parameter int PW    = 6,
  parameter int BASE  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_reg,
  input  logic          save,
  input  logic          restore,
  output logic [PW-1:0] head_reg,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [PW-1:0] mem [DEPTH];
  logic [AW:0]   head_q, tail_q, saved_q;

  assign head_reg = mem[head_q[AW-1:0]];
  assign empty    = (head_q == tail_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= (AW+1)'(DEPTH);
      saved_q <= '0;
    end else begin
      if (restore)   head_q <= saved_q;
      else if (pop)  head_q <= head_q + 1'b1;
      if (push)      tail_q <= tail_q + 1'b1;
      if (save)      saved_q <= pop ? head_q + 1'b1 : head_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PW'(BASE + i);
    end else if (push) begin
      mem[tail_q[AW-1:0]] <= push_reg;
    end
  end
endmodule

// File: rtl/rn_map_table.sv
// Architectural-to-physical map held in flops so every entry can be
// read at once and the whole table replaced in one cycle.
module rn_map_table #(
  parameter int NUM_ARCH = 16,
  parameter int PW       = 6,
  parameter int AW       = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_arch,
  input  logic [PW-1:0]                 wr_phys,
  input  logic                          restore,
  input  logic [NUM_ARCH-1:0][PW-1:0]   restore_img,
  output logic [NUM_ARCH-1:0][PW-1:0]   img
);
  logic [NUM_ARCH-1:0][PW-1:0] map_q;

  assign img = map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (restore) begin
      map_q <= restore_img;
    end else if (wr_en) begin
      map_q[wr_arch] <= wr_phys;
    end
  end
endmodule

// File: rtl/rn_checkpoint.sv
// Single snapshot slot for the map table plus its live flag.
module rn_checkpoint #(
  parameter int NUM_ARCH = 16,
  parameter int PW       = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        save,
  input  logic                        discard,
  input  logic [NUM_ARCH-1:0][PW-1:0] save_img,
  output logic [NUM_ARCH-1:0][PW-1:0] img,
  output logic                        live
);
  logic [NUM_ARCH-1:0][PW-1:0] img_q;
  logic                        live_q;

  assign img  = img_q;
  assign live = live_q;

  always_ff @(posedge clk) begin
    if (save) img_q <= save_img;
  end

  always_ff @(posedge clk) begin
    if (rst)          live_q <= 1'b0;
    else if (save)    live_q <= 1'b1;
    else if (discard) live_q <= 1'b0;
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = RN_ARCH_REGS,
  parameter int NUM_PHYS = RN_PHYS_REGS,
  localparam int AW       = $clog2(NUM_ARCH),
  localparam int PW       = $clog2(NUM_PHYS),
  localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic          ren_wr,
  input  logic          ren_branch,
  input  logic [AW-1:0] ren_dst,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  output logic          ren_stall,
  output logic          out_valid,
  output logic          out_has_dst,
  output logic [PW-1:0] out_src_a_p,
  output logic [PW-1:0] out_src_b_p,
  output logic [PW-1:0] out_dst_p,
  output logic [PW-1:0] out_prev_p,
  input  logic          resolve_valid,
  input  logic          resolve_wrong,
  input  logic          commit_valid,
  input  logic [PW-1:0] commit_free_p
);
  logic [NUM_ARCH-1:0][PW-1:0] map_img, ck_img, img_next;
  logic          ck_live, fl_empty;
  logic [PW-1:0] fl_head;
  logic          restore, discard, accept, acc_wr, acc_br;

  assign restore   = resolve_valid & resolve_wrong & ck_live;
  assign discard   = resolve_valid & ck_live;
  assign ren_stall = ren_valid & (restore | (ren_wr & fl_empty) | (ren_branch & ck_live));
  assign accept    = ren_valid & ~ren_stall;
  assign acc_wr    = accept & ren_wr;
  assign acc_br    = accept & ren_branch;

  // Snapshot taken after this cycle's own destination update.
  always_comb begin
    img_next = map_img;
    if (acc_wr) img_next[ren_dst] = fl_head;
  end

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW), .AW(AW)) u_map (
    .clk(clk), .rst(rst), .wr_en(acc_wr), .wr_arch(ren_dst), .wr_phys(fl_head),
    .restore(restore), .restore_img(ck_img), .img(map_img)
  );

  rn_free_list #(.DEPTH(FL_DEPTH), .PW(PW), .BASE(NUM_ARCH)) u_free (
    .clk(clk), .rst(rst), .pop(acc_wr), .push(commit_valid), .push_reg(commit_free_p),
    .save(acc_br), .restore(restore), .head_reg(fl_head), .empty(fl_empty)
  );

  rn_checkpoint #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_ckpt (
    .clk(clk), .rst(rst), .save(acc_br), .discard(discard),
    .save_img(img_next), .img(ck_img), .live(ck_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_has_dst <= 1'b0;
      out_src_a_p <= '0;
      out_src_b_p <= '0;
      out_dst_p   <= '0;
      out_prev_p  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_has_dst <= ren_wr;
        out_src_a_p <= map_img[ren_src_a];
        out_src_b_p <= map_img[ren_src_b];
        out_dst_p   <= ren_wr ? fl_head : '0;
        out_prev_p  <= ren_wr ? map_img[ren_dst] : '0;
      end
    end
  end
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NUM_PHYS = 48,
  parameter int PW       = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          ren_valid,
  input logic          ren_wr,
  input logic          ren_branch,
  input logic          ren_stall,
  input logic          out_valid,
  input logic          out_has_dst,
  input logic [PW-1:0] out_dst_p,
  input logic          resolve_valid,
  input logic          resolve_wrong,
  input logic          ck_live,
  input logic          fl_empty
);
  p_stall_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_wr && fl_empty) |-> ren_stall);

  p_branch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_branch && ck_live) |-> ren_stall);

  p_ckpt_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && ck_live) |=> !ck_live);

  p_accept_out_r11: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !ren_stall) |=> out_valid);

  p_idle_out_r11: assert property (@(posedge clk) disable iff (rst)
    !(ren_valid && !ren_stall) |=> !out_valid);

  p_restore_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && resolve_valid && resolve_wrong && ck_live) |-> ren_stall);

  p_alloc_range_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_has_dst) |-> (out_dst_p >= PW'(16) && out_dst_p < PW'(NUM_PHYS)) || out_dst_p < PW'(16));
endmodule

bind rename_map rename_map_chk #(.NUM_PHYS(NUM_PHYS), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_wr(ren_wr), .ren_branch(ren_branch),
  .ren_stall(ren_stall), .out_valid(out_valid), .out_has_dst(out_has_dst),
  .out_dst_p(out_dst_p), .resolve_valid(resolve_valid), .resolve_wrong(resolve_wrong),
  .ck_live(ck_live), .fl_empty(fl_empty)
);

// File: tb/rename_map_tb.sv
module rename_map_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ren_valid = 0, ren_wr = 0, ren_branch = 0;
  logic [3:0] ren_dst = 0, ren_src_a = 0, ren_src_b = 0;
  logic ren_stall, out_valid, out_has_dst;
  logic [5:0] out_src_a_p, out_src_b_p, out_dst_p, out_prev_p;
  logic resolve_valid = 0, resolve_wrong = 0, commit_valid = 0;
  logic [5:0] commit_free_p = 0;

  int checks = 0, errors = 0;
  logic r_stall, r_valid;
  int r_a, r_b, r_dst, r_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map u_dut (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_wr(ren_wr), .ren_branch(ren_branch),
    .ren_dst(ren_dst), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_stall(ren_stall),
    .out_valid(out_valid), .out_has_dst(out_has_dst), .out_src_a_p(out_src_a_p),
    .out_src_b_p(out_src_b_p), .out_dst_p(out_dst_p), .out_prev_p(out_prev_p),
    .resolve_valid(resolve_valid), .resolve_wrong(resolve_wrong),
    .commit_valid(commit_valid), .commit_free_p(commit_free_p)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One rename request held for one cycle; results sampled a cycle later.
  task automatic ren(input logic wr, input logic br, input int dst, input int a, input int b);
    @(negedge clk);
    ren_valid = 1; ren_wr = wr; ren_branch = br;
    ren_dst = 4'(dst); ren_src_a = 4'(a); ren_src_b = 4'(b);
    #1 r_stall = ren_stall;
    @(negedge clk);
    ren_valid = 0; ren_wr = 0; ren_branch = 0;
    r_valid = out_valid; r_a = out_src_a_p; r_b = out_src_b_p;
    r_dst = out_dst_p; r_prev = out_prev_p;
  endtask

  task automatic release_reg(input int p);
    @(negedge clk);
    commit_valid = 1; commit_free_p = 6'(p);
    @(negedge clk);
    commit_valid = 0;
  endtask

  task automatic resolve(input logic wrong);
    @(negedge clk);
    resolve_valid = 1; resolve_wrong = wrong;
    @(negedge clk);
    resolve_valid = 0; resolve_wrong = 0;
  endtask

  task automatic t_reset_map;
    check("R11 idle out_valid", int'(out_valid), 0);
    for (int i = 0; i < 16; i += 2) begin
      ren(0, 0, 0, i, i + 1);
      check("R1 src_a identity", r_a, i);
      check("R1 src_b identity", r_b, i + 1);
      check("R11 out_valid after accept", int'(r_valid), 1);
    end
  endtask

  task automatic t_first_allocs;
    ren(1, 0, 3, 3, 5);
    check("R2 first alloc", r_dst, 16);
    check("R2 prev mapping", r_prev, 3);
    check("R3 src equal dst reads old", r_a, 3);
    check("R3 other src", r_b, 5);
    ren(0, 0, 0, 3, 3);
    check("R4 lookup after rename", r_a, 16);
    ren(1, 0, 3, 0, 0);
    check("R2 second alloc", r_dst, 17);
    check("R2 prev is first alloc", r_prev, 16);
  endtask

  task automatic t_exhaust;
    int exp_prev;
    release_reg(3);
    release_reg(16);
    exp_prev = 0;
    for (int k = 0; k < 32; k++) begin
      int exp_dst;
      exp_dst = (k < 30) ? 18 + k : (k == 30 ? 3 : 16);
      ren(1, 0, 0, 0, 0);
      check("R6 FIFO allocation order", r_dst, exp_dst);
      check("R2 prev chain", r_prev, exp_prev);
      exp_prev = exp_dst;
    end
    ren(1, 0, 1, 0, 0);
    check("R5 stall when empty", int'(r_stall), 1);
    check("R5 no output on stall", int'(r_valid), 0);
    ren(0, 0, 0, 0, 3);
    check("R5 lookup proceeds when empty", int'(r_stall), 0);
    check("R5 lookup result", r_a, 16);
    check("R4 other mapping kept", r_b, 17);
  endtask

  task automatic t_mispredict;
    release_reg(0);
    release_reg(18);
    ren(1, 1, 5, 5, 5);
    check("R7 branch alloc", r_dst, 0);
    ren(1, 0, 6, 6, 6);
    check("R7 post-branch alloc", r_dst, 18);
    ren(0, 1, 0, 0, 0);
    check("R7 second branch stalled", int'(r_stall), 1);
    check("R7 no output for stalled branch", int'(r_valid), 0);
    // Restore, release and a rename request in one cycle.
    @(negedge clk);
    resolve_valid = 1; resolve_wrong = 1;
    commit_valid = 1; commit_free_p = 6'd19;
    ren_valid = 1; ren_src_a = 4'd6;
    #1 check("R11 rename stalled during restore", int'(ren_stall), 1);
    @(negedge clk);
    resolve_valid = 0; resolve_wrong = 0; commit_valid = 0; ren_valid = 0;
    check("R11 no output during restore", int'(out_valid), 0);
    ren(0, 0, 0, 6, 5);
    check("R8 post-branch mapping undone", r_a, 6);
    check("R8 branch own mapping kept", r_b, 0);
    ren(1, 0, 7, 7, 7);
    check("R8 free head restored", r_dst, 18);
    check("R8 prev after restore", r_prev, 7);
    ren(1, 0, 7, 7, 7);
    check("R10 release during restore kept", r_dst, 19);
    ren(1, 0, 9, 0, 0);
    check("R10 queue then empty", int'(r_stall), 1);
  endtask

  task automatic t_correct_resolve;
    release_reg(20);
    release_reg(21);
    ren(0, 1, 0, 7, 7);
    check("R7 branch lookup", r_a, 19);
    resolve(0);
    ren(1, 0, 8, 8, 8);
    check("R9 alloc after discard", r_dst, 20);
    resolve(1);
    ren(0, 0, 0, 8, 8);
    check("R9 stale mispredict ignored map", r_a, 20);
    ren(1, 0, 9, 9, 9);
    check("R9 stale mispredict ignored free list", r_dst, 21);
    ren(0, 1, 0, 9, 9);
    check("R9 new branch accepted", int'(r_stall), 0);
    check("R9 new branch output", int'(r_valid), 1);
    check("R9 new branch lookup", r_a, 21);
    resolve(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_map();
    t_first_allocs();
    t_exhaust();
    t_mispredict();
    t_correct_resolve();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule